// File: doc/BRIEF.md
# Stride Address Prediction Table

This block predicts the effective address of a memory instruction from that instruction's own history. It is a direct-mapped table indexed by the program counter. Each slot keeps a tag, the last effective address observed for that instruction, the difference between its last two addresses (the stride) and a 2-bit saturating confidence state. A prediction is the stored last address plus the stored stride. It is offered only while the confidence is in one of its two upper states.

The block has two ports that work independently. The lookup port takes a PC and, one clock later, returns a valid flag and a predicted address. The update port takes a PC and the resolved address of the same instruction. In that same cycle it reads the slot, judges the last prediction and writes back the retrained slot. A miss on update replaces the slot. A lookup that lands in the same cycle as an update to the same slot sees the contents as they were before the update.

The confidence state machine has four named states: `CONF_NONE` (00, no prediction), `CONF_WEAK_NONE` (01, weak no-prediction), `CONF_WEAK_PRED` (10, weak prediction) and `CONF_PRED` (11, prediction). It has three named transitions:
- `step up`: a correct judgement moves the state one place toward `CONF_PRED`. In `CONF_PRED` the state holds.
- `step down`: a wrong judgement moves the state one place toward `CONF_NONE`. In `CONF_NONE` the state holds.
- `allocate`: a tag miss forces the state to `CONF_NONE`.

Top module: `stride_addr_pred`

## Requirements
- R1: After reset every slot is empty, so any lookup returns `lk_valid_o` = 0.
- R2: A lookup request in cycle N gives its result in cycle N+1. `lk_valid_o` is 1 only when the request was made, the tag matched and bit 1 of the confidence was 1. `lk_addr_o` is the stored last address plus the stored stride when valid, and zero otherwise. A cycle with `lk_req_i` low gives `lk_valid_o` = 0 in the next cycle.
- R3: The slot index is PC bits [PC_LSB +: IDX_W], which is bits [11:2] by default. The tag is the PC bits above the index. A lookup whose tag differs from the stored tag misses and gives `lk_valid_o` = 0.
- R4: An update that misses writes the new tag, sets the last address to the actual address, sets the stride to zero and sets the confidence to 00. This evicts the previous occupant of the slot.
- R5: An update that hits judges the prediction correct when the old last address plus the old stride equals the actual address. It then sets the stride to the actual address minus the old last address and sets the last address to the actual address. All arithmetic is modulo 2^ADDR_W, so negative strides work.
- R6: The confidence encodings are 11 = predict, 10 = weakly predict, 01 = weakly no-predict and 00 = no-predict. It steps up by one on a correct judgement and stays at 11 there. It steps down by one on a wrong judgement and stays at 00 there.
- R7: A lookup and an update to the same index in the same cycle give the lookup result computed from the slot contents before that update.
- R8: An update changes only the slot selected by its own PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req_i | input | 1 | Lookup request |
| lk_pc_i | input | PC_W | PC of the instruction to predict |
| lk_valid_o | output | 1 | Prediction offered (one cycle after the request) |
| lk_addr_o | output | ADDR_W | Predicted effective address |
| up_req_i | input | 1 | Update request |
| up_pc_i | input | PC_W | PC of the resolved instruction |
| up_addr_i | input | ADDR_W | Actual effective address |

## Verification
A lookup and an update can both touch the same slot in one clock. The bench provokes this by training a slot to the weak-predict state. It then drives a lookup and a mispredicting update for that PC in the same cycle. The lookup must still report the old valid prediction, and a follow-up lookup must show that the confidence dropped below the prediction threshold. Separate directed scenarios cover stride training, both saturation ends, negative strides, eviction on a tag alias, and isolation between slots.

// File: rtl/sapt_pkg.sv
`timescale 1ns/1ps
package sapt_pkg;

    typedef enum logic [1:0] {
        CONF_NONE      = 2'b00,
        CONF_WEAK_NONE = 2'b01,
        CONF_WEAK_PRED = 2'b10,
        CONF_PRED      = 2'b11
    } conf_e;

    // Upper confidence bit set means a prediction may be offered.
    function automatic logic conf_offers(input conf_e c);
        return c[1];
    endfunction

endpackage

// File: rtl/sapt_index_split.sv
`timescale 1ns/1ps
module sapt_index_split #(
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2,
    parameter int IDX_W  = 10,
    parameter int TAG_W  = PC_W - PC_LSB - IDX_W
) (
    input  logic [PC_W-1:0]  pc_i,
    output logic [IDX_W-1:0] idx_o,
    output logic [TAG_W-1:0] tag_o
);
    assign idx_o = pc_i[PC_LSB +: IDX_W];
    assign tag_o = pc_i[PC_LSB+IDX_W +: TAG_W];

    if (PC_LSB > 0) begin : g_low_bits
        logic [PC_LSB-1:0] unused_low;
        assign unused_low = pc_i[PC_LSB-1:0];
    end
endmodule

// File: rtl/sapt_conf_fsm.sv
`timescale 1ns/1ps
module sapt_conf_fsm
    import sapt_pkg::*;
(
    input  conf_e cur_i,
    input  logic  hit_i,
    input  logic  correct_i,
    output conf_e nxt_o,
    output logic  offers_o
);
    // Next-state process
    always_comb begin
        nxt_o = CONF_NONE;
        if (hit_i) begin
            unique case (cur_i)
                CONF_NONE:      nxt_o = correct_i ? CONF_WEAK_NONE : CONF_NONE;
                CONF_WEAK_NONE: nxt_o = correct_i ? CONF_WEAK_PRED : CONF_NONE;
                CONF_WEAK_PRED: nxt_o = correct_i ? CONF_PRED      : CONF_WEAK_NONE;
                CONF_PRED:      nxt_o = correct_i ? CONF_PRED      : CONF_WEAK_PRED;
                default:        nxt_o = CONF_NONE;
            endcase
        end
    end

    // Output process
    always_comb begin
        offers_o = conf_offers(cur_i);
    end
endmodule

// File: rtl/sapt_table.sv
`timescale 1ns/1ps
module sapt_table
    import sapt_pkg::*;
#(
    parameter int ENTRIES = 1024,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int TAG_W   = 20,
    parameter int ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    // registered lookup read
    input  logic              rd_en_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    input  logic [TAG_W-1:0]  rd_tag_i,
    output logic              rd_valid_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    // combinational update read
    input  logic [IDX_W-1:0]  ur_idx_i,
    output logic              ur_vld_o,
    output logic [TAG_W-1:0]  ur_tag_o,
    output logic [ADDR_W-1:0] ur_prev_o,
    output logic [ADDR_W-1:0] ur_stride_o,
    output conf_e             ur_conf_o,
    // write
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [TAG_W-1:0]  wr_tag_i,
    input  logic [ADDR_W-1:0] wr_prev_i,
    input  logic [ADDR_W-1:0] wr_stride_i,
    input  conf_e             wr_conf_i
);
    logic [ENTRIES-1:0] vld_q;
    logic [TAG_W-1:0]   tag_q    [ENTRIES];
    logic [ADDR_W-1:0]  prev_q   [ENTRIES];
    logic [ADDR_W-1:0]  stride_q [ENTRIES];
    conf_e              conf_q   [ENTRIES];

    logic rd_hit;
    assign rd_hit = vld_q[rd_idx_i] && (tag_q[rd_idx_i] == rd_tag_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en_i) begin
            vld_q[wr_idx_i] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en_i) begin
            tag_q[wr_idx_i]    <= wr_tag_i;
            prev_q[wr_idx_i]   <= wr_prev_i;
            stride_q[wr_idx_i] <= wr_stride_i;
            conf_q[wr_idx_i]   <= wr_conf_i;
        end
    end

    // Read before write: same-edge update is not visible here.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_addr_o  <= '0;
        end else if (rd_en_i && rd_hit && conf_offers(conf_q[rd_idx_i])) begin
            rd_valid_o <= 1'b1;
            rd_addr_o  <= prev_q[rd_idx_i] + stride_q[rd_idx_i];
        end else begin
            rd_valid_o <= 1'b0;
            rd_addr_o  <= '0;
        end
    end

    assign ur_vld_o    = vld_q[ur_idx_i];
    assign ur_tag_o    = tag_q[ur_idx_i];
    assign ur_prev_o   = prev_q[ur_idx_i];
    assign ur_stride_o = stride_q[ur_idx_i];
    assign ur_conf_o   = conf_q[ur_idx_i];

    AST_MISS_NO_PRED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_i && !rd_hit |=> !rd_valid_o); // R3

endmodule

// File: rtl/stride_addr_pred.sv
`timescale 1ns/1ps
module stride_addr_pred
    import sapt_pkg::*;
#(
    parameter int PC_W    = 32,
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 1024,
    parameter int PC_LSB  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_req_i,
    input  logic [PC_W-1:0]   lk_pc_i,
    output logic              lk_valid_o,
    output logic [ADDR_W-1:0] lk_addr_o,
    input  logic              up_req_i,
    input  logic [PC_W-1:0]   up_pc_i,
    input  logic [ADDR_W-1:0] up_addr_i
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int TAG_W = PC_W - PC_LSB - IDX_W;

    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic [TAG_W-1:0]  lk_tag, up_tag;
    logic              ur_vld;
    logic [TAG_W-1:0]  ur_tag;
    logic [ADDR_W-1:0] ur_prev, ur_stride;
    conf_e             ur_conf, wr_conf;
    logic              up_hit, up_correct, ur_offers;
    logic [ADDR_W-1:0] wr_stride;

    sapt_index_split #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lk_split (
        .pc_i(lk_pc_i), .idx_o(lk_idx), .tag_o(lk_tag));

    sapt_index_split #(.PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_up_split (
        .pc_i(up_pc_i), .idx_o(up_idx), .tag_o(up_tag));

    assign up_hit     = ur_vld && (ur_tag == up_tag);
    assign up_correct = (ur_prev + ur_stride) == up_addr_i;
    assign wr_stride  = up_hit ? (up_addr_i - ur_prev) : '0;

    sapt_conf_fsm u_fsm (
        .cur_i(ur_conf), .hit_i(up_hit), .correct_i(up_correct),
        .nxt_o(wr_conf), .offers_o(ur_offers));

    logic unused_offers;
    assign unused_offers = ur_offers;

    sapt_table #(.ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .ADDR_W(ADDR_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .rd_en_i(lk_req_i), .rd_idx_i(lk_idx), .rd_tag_i(lk_tag),
        .rd_valid_o(lk_valid_o), .rd_addr_o(lk_addr_o),
        .ur_idx_i(up_idx), .ur_vld_o(ur_vld), .ur_tag_o(ur_tag),
        .ur_prev_o(ur_prev), .ur_stride_o(ur_stride), .ur_conf_o(ur_conf),
        .wr_en_i(up_req_i), .wr_idx_i(up_idx), .wr_tag_i(up_tag),
        .wr_prev_i(up_addr_i), .wr_stride_i(wr_stride), .wr_conf_i(wr_conf));

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid_o |-> $past(lk_req_i)); // R2

    AST_ADDR_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid_o |-> (lk_addr_o == '0)); // R2

    AST_ALLOC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        up_req_i && !up_hit |-> (wr_conf == CONF_NONE) && (wr_stride == '0)); // R4

    AST_CONF_UP: assert property (@(posedge clk) disable iff (!rst_n)
        up_req_i && up_hit && up_correct |-> (wr_conf >= ur_conf)); // R6

    AST_CONF_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        up_req_i && up_hit && !up_correct |-> (wr_conf <= ur_conf)); // R6

endmodule

// File: tb/stride_addr_pred_bench.sv
`timescale 1ns/1ps
module stride_addr_pred_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_req_i = 1'b0;
    logic [31:0] lk_pc_i = '0;
    logic        lk_valid_o;
    logic [31:0] lk_addr_o;
    logic        up_req_i = 1'b0;
    logic [31:0] up_pc_i = '0;
    logic [31:0] up_addr_i = '0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    stride_addr_pred u_stride_addr_pred (
        .clk(clk), .rst_n(rst_n),
        .lk_req_i(lk_req_i), .lk_pc_i(lk_pc_i),
        .lk_valid_o(lk_valid_o), .lk_addr_o(lk_addr_o),
        .up_req_i(up_req_i), .up_pc_i(up_pc_i), .up_addr_i(up_addr_i));

    task automatic check(input string req, input logic v, input logic [31:0] a,
                         input logic ev, input logic [31:0] ea);
        n_run++;
        if (v !== ev || a !== ea) begin
            n_fail++;
            $display("FAIL %s: got valid=%0b addr=%0d, expected valid=%0b addr=%0d",
                     req, v, a, ev, ea);
        end
    endtask

    task automatic upd(input logic [31:0] pc, input logic [31:0] addr);
        @(negedge clk);
        up_req_i = 1'b1; up_pc_i = pc; up_addr_i = addr;
        @(negedge clk);
        up_req_i = 1'b0;
    endtask

    task automatic look(input string req, input logic [31:0] pc, input logic req_en,
                        input logic ev, input logic [31:0] ea);
        @(negedge clk);
        lk_req_i = req_en; lk_pc_i = pc;
        @(negedge clk);
        lk_req_i = 1'b0;
        check(req, lk_valid_o, lk_addr_o, ev, ea);
    endtask

    task automatic t_reset();
        check("R1 reset outputs", lk_valid_o, lk_addr_o, 1'b0, 32'd0);
        look("R1 empty after reset", 32'h1000_0040, 1'b1, 1'b0, 32'd0);
    endtask

    task automatic t_stride_train();
        logic [31:0] a = 32'h1000_0040;
        upd(a, 100);                                          // alloc 00
        look("R4 fresh slot no prediction", a, 1'b1, 1'b0, 0);
        upd(a, 104);                                          // wrong, stays 00 (R6 floor)
        look("R6 floor holds at 00", a, 1'b1, 1'b0, 0);
        upd(a, 108);                                          // 01
        look("R6 weak no-predict offers nothing", a, 1'b1, 1'b0, 0);
        upd(a, 112);                                          // 10
        look("R5 weak predict prev+stride", a, 1'b1, 1'b1, 116);
        upd(a, 116);                                          // 11
        upd(a, 120);                                          // 11 saturates
        look("R6 predict saturates", a, 1'b1, 1'b1, 124);
        look("R2 no request no result", a, 1'b0, 1'b0, 0);
        upd(a, 200);                                          // wrong 11->10
        look("R6 one miss from 11 still predicts", a, 1'b1, 1'b1, 280);
        upd(a, 300);                                          // wrong 10->01
        look("R6 second miss stops prediction", a, 1'b1, 1'b0, 0);
    endtask

    task automatic t_negative_stride();
        logic [31:0] a = 32'h0000_0200;
        upd(a, 1000); upd(a, 990); upd(a, 980); upd(a, 970);
        look("R5 negative stride", a, 1'b1, 1'b1, 960);
    endtask

    task automatic t_alias();
        logic [31:0] a = 32'h0000_0200;
        logic [31:0] b = 32'h3000_0200;                       // same index bits [11:2]
        look("R3 tag mismatch misses", b, 1'b1, 1'b0, 0);
        upd(b, 5000);                                         // evicts a
        look("R4 evicted owner misses", a, 1'b1, 1'b0, 0);
        upd(b, 5004); upd(b, 5008); upd(b, 5012);
        look("R4 new owner trains from zero", b, 1'b1, 1'b1, 5016);
    endtask

    task automatic t_same_cycle();
        logic [31:0] c = 32'h0000_0300;
        upd(c, 500); upd(c, 510); upd(c, 520); upd(c, 530);  // conf 10
        @(negedge clk);
        lk_req_i = 1'b1; lk_pc_i = c;
        up_req_i = 1'b1; up_pc_i = c; up_addr_i = 999;
        @(negedge clk);
        lk_req_i = 1'b0; up_req_i = 1'b0;
        check("R7 collision returns old contents", lk_valid_o, lk_addr_o, 1'b1, 540);
        look("R7 update took effect after", c, 1'b1, 1'b0, 0);
    endtask

    task automatic t_isolation();
        logic [31:0] d = 32'h0000_0400;
        logic [31:0] e = 32'h0000_0404;
        upd(d, 0); upd(d, 8); upd(d, 16); upd(d, 24);
        for (int i = 0; i < 4; i++) upd(e, 32'(i * 7 + 3000));
        look("R8 neighbour updates leave slot intact", d, 1'b1, 1'b1, 32);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stride_train();
        t_negative_stride();
        t_alias();
        t_same_cycle();
        t_isolation();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            done = 1'b1;
            n_run++; n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule